// File: doc/BRIEF.md
# Fractional Divider Rate Solver

This block works out the setting for a fractional clock divider whose output frequency is the parent frequency times eighteen, divided by an integer fraction. A client presents a parent frequency and a wanted output frequency and pulses a start strobe. The block picks the fraction nearest to the request, limits it to the range the divider accepts, and reports both the fraction and the frequency that fraction really produces.

Both divisions go through one iterative restoring divider that retires one quotient bit per clock. The result therefore arrives after a fixed number of cycles. A request for zero hertz does not divide at all. It is flagged as an error and answered with the slowest legal fraction. While a request is in flight the unit ignores further start strobes. Each result stays on the outputs until the next one replaces it.

Top module: `frac_rate_solver`

## Requirements
- R1: After synchronous reset `busy_o`, `done_o` and `zero_err_o` are 0, and `frac_o` and `rate_o` are 0.
- R2: For a nonzero wanted frequency T and parent P, the fraction is floor((18·P + floor(T/2)) / T) whenever that value lies within 12..35.
- R3: A computed fraction below 12 is reported as 12, and one above 35 is reported as 35.
- R4: `rate_o` equals floor(18·P / F), where F is the reported (limited) fraction. `rate_o` is FREQ_W+1 bits wide, so the value 1.5·P reached at F = 12 is never truncated.
- R5: When T is 0, `zero_err_o` is 1, `frac_o` is 35 and `rate_o` is floor(18·P / 35). For any nonzero T, `zero_err_o` is 0.
- R6: A start strobe is taken only while `busy_o` is 0. A strobe raised while busy has no effect on the result. Input values that change after the accepting edge have no effect on the result either.
- R7: `done_o` is high for exactly one cycle. `frac_o`, `rate_o` and `zero_err_o` change only in the cycle in which `done_o` rises.
- R8: `done_o` rises 2·(PROD_W+2) clock edges after the edge that accepts start when T is nonzero, and PROD_W+2 edges after it when T is 0. A start raised in the `done_o` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, sampled while idle |
| parent_i | input | FREQ_W | Parent frequency P |
| target_i | input | FREQ_W | Wanted output frequency T |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle result strobe |
| frac_o | output | FRAC_W | Limited fraction F |
| rate_o | output | FREQ_W+1 | Achieved frequency floor(18·P/F) |
| zero_err_o | output | 1 | The last request asked for 0 Hz |

## Verification
Publishing a result and accepting the next request can happen in the same cycle. The `done_o` cycle is also the first idle cycle, so a start raised there is taken while the previous result is still being shown. The bench issues every new request exactly in the preceding `done_o` cycle. One cycle later it checks that `done_o` has dropped and that the old fraction, rate and error flag are unchanged. It also checks the exact latency of the new request. Some requests are also hit by a stray start strobe with different operands mid-computation, and their results must match the original operands.

// File: rtl/frac_solver_pkg.sv
package frac_solver_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RATIO = 2'd1,
    ST_RATE  = 2'd2
  } solver_state_e;
endpackage

// File: rtl/frac_restoring_div.sv
module frac_restoring_div #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(DVD_W);

  logic [DVD_W-1:0] shreg;
  logic [DVS_W-1:0] rem;
  logic [DVS_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             fits;

  // trial remainder: previous remainder with the next dividend bit appended
  always_comb begin
    trial = {rem, shreg[DVD_W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      rem    <= '0;
      dvs_q  <= '0;
      cnt    <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go && !busy_o) begin
        shreg  <= dividend;
        rem    <= '0;
        dvs_q  <= divisor;
        cnt    <= CNT_W'(DVD_W - 1);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rem   <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        shreg <= {shreg[DVD_W-2:0], fits};
        if (cnt == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign quot_o = shreg;

  // R8: a result strobe only ends an active iteration
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o));
  // R8: exactly one quotient bit per cycle
  a_r8_one_bit_per_cycle: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> (cnt == CNT_W'($past(cnt) - 1'b1)));
  // R5: a zero divisor must never reach the iteration
  a_r5_nonzero_divisor: assert property (@(posedge clk) disable iff (rst)
    (go && !busy_o) |-> (divisor != '0));
  // R2: restoring invariant, the remainder stays below the divisor
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (rem < dvs_q));
endmodule

// File: rtl/frac_clamp.sv
module frac_clamp #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 6,
  parameter int LO    = 12,
  parameter int HI    = 35
) (
  input  logic [IN_W-1:0]  raw_i,
  output logic [OUT_W-1:0] frac_o
);
  always_comb begin
    if (raw_i < IN_W'(LO))       frac_o = OUT_W'(LO);
    else if (raw_i > IN_W'(HI))  frac_o = OUT_W'(HI);
    else                         frac_o = raw_i[OUT_W-1:0];
  end
endmodule

// File: rtl/frac_rate_solver.sv
module frac_rate_solver
  import frac_solver_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PROD_W  = 64,
  parameter int SCALE   = 18,
  parameter int FRAC_LO = 12,
  parameter int FRAC_HI = 35,
  localparam int FRAC_W = $clog2(FRAC_HI + 1),
  localparam int RATE_W = FREQ_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] parent_i,
  input  logic [FREQ_W-1:0] target_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              zero_err_o
);
  solver_state_e     state;
  logic [PROD_W-1:0] scaled_q;
  logic [PROD_W-1:0] scaled_in;
  logic [PROD_W-1:0] div_dvd;
  logic [FREQ_W-1:0] div_dvs;
  logic              div_go;
  logic              div_busy;
  logic              div_done;
  logic [PROD_W-1:0] div_quot;
  logic [FRAC_W-1:0] frac_lim;
  logic [FRAC_W-1:0] frac_q;
  logic              err_q;

  assign scaled_in = PROD_W'(parent_i) * PROD_W'(SCALE);

  frac_restoring_div #(.DVD_W(PROD_W), .DVS_W(FREQ_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .busy_o   (div_busy),
    .done_o   (div_done),
    .quot_o   (div_quot)
  );

  frac_clamp #(.IN_W(PROD_W), .OUT_W(FRAC_W), .LO(FRAC_LO), .HI(FRAC_HI)) u_clamp (
    .raw_i  (div_quot),
    .frac_o (frac_lim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      scaled_q   <= '0;
      div_dvd    <= '0;
      div_dvs    <= '0;
      div_go     <= 1'b0;
      frac_q     <= '0;
      err_q      <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      frac_o     <= '0;
      rate_o     <= '0;
      zero_err_o <= 1'b0;
    end else begin
      div_go <= 1'b0;
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            scaled_q <= scaled_in;
            div_go   <= 1'b1;
            busy_o   <= 1'b1;
            if (target_i == '0) begin
              err_q   <= 1'b1;
              frac_q  <= FRAC_W'(FRAC_HI);
              div_dvd <= scaled_in;
              div_dvs <= FREQ_W'(FRAC_HI);
              state   <= ST_RATE;
            end else begin
              err_q   <= 1'b0;
              div_dvd <= scaled_in + PROD_W'(target_i >> 1);
              div_dvs <= target_i;
              state   <= ST_RATIO;
            end
          end
        end
        ST_RATIO: begin
          if (div_done) begin
            frac_q  <= frac_lim;
            div_dvd <= scaled_q;
            div_dvs <= FREQ_W'(frac_lim);
            div_go  <= 1'b1;
            state   <= ST_RATE;
          end
        end
        ST_RATE: begin
          if (div_done) begin
            frac_o     <= frac_q;
            rate_o     <= div_quot[RATE_W-1:0];
            zero_err_o <= err_q;
            done_o     <= 1'b1;
            busy_o     <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(frac_o) && $stable(rate_o) && $stable(zero_err_o)));
  a_r3_frac_range: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (frac_o >= FRAC_W'(FRAC_LO) && frac_o <= FRAC_W'(FRAC_HI)));
  a_r5_zero_frac: assert property (@(posedge clk) disable iff (rst)
    (done_o && zero_err_o) |-> (frac_o == FRAC_W'(FRAC_HI)));
  a_r4_rate_fits: assert property (@(posedge clk) disable iff (rst)
    (div_done && state == ST_RATE) |-> (div_quot[PROD_W-1:RATE_W] == '0));
  a_r6_accept: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  a_r8_div_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !div_busy);
endmodule

// File: tb/tb_frac_rate_solver.sv
`timescale 1ns/1ps
module tb_frac_rate_solver;
  localparam int FW = 8;
  localparam int PW = 16;
  localparam int LAT_FULL = 2 * (PW + 2);
  localparam int LAT_ZERO = PW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [FW-1:0] parent_i = '0;
  logic [FW-1:0] target_i = '0;
  logic          busy_o, done_o, zero_err_o;
  logic [5:0]    frac_o;
  logic [FW:0]   rate_o;

  int checks = 0;
  int fails  = 0;
  int prev_frac = 0, prev_rate = 0, prev_err = 0;

  always #2.5 clk = ~clk;

  frac_rate_solver #(.FREQ_W(FW), .PROD_W(PW)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .parent_i(parent_i),
    .target_i(target_i), .busy_o(busy_o), .done_o(done_o),
    .frac_o(frac_o), .rate_o(rate_o), .zero_err_o(zero_err_o)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run(input int p, input int r, input bit stray);
    int sc, q, f, rt, lat, cnt;
    string tag;
    sc = p * 18;
    if (r == 0) begin
      f = 35; tag = "R5"; lat = LAT_ZERO;
    end else begin
      q = (sc + r / 2) / r;
      lat = LAT_FULL;
      if (q < 12) begin f = 12; tag = "R3"; end
      else if (q > 35) begin f = 35; tag = "R3"; end
      else begin f = q; tag = "R2"; end
    end
    rt = sc / f;
    start_i  = 1'b1;
    parent_i = FW'(p);
    target_i = FW'(r);
    @(negedge clk);
    start_i  = 1'b0;
    parent_i = FW'(255 - p);           // R6: late operand change
    target_i = FW'(r + 1);
    cnt = 0;
    chk(done_o == 1'b0, "R7 done pulse", done_o, 0);
    chk(frac_o == prev_frac && rate_o == prev_rate && zero_err_o == prev_err,
        "R7 hold", frac_o, prev_frac);
    while (!done_o && cnt < 200) begin
      if (stray && cnt == 3) begin
        start_i  = 1'b1;               // R6: start while busy
        target_i = FW'(r ^ 8'h5A);
      end else start_i = 1'b0;
      @(negedge clk);
      cnt++;
    end
    start_i = 1'b0;
    chk(cnt == lat, "R8 latency", cnt, lat);
    chk(int'(frac_o) == f, tag, frac_o, f);
    chk(int'(rate_o) == rt, "R4 rate", rate_o, rt);
    chk(zero_err_o == (r == 0), "R5 err flag", zero_err_o, (r == 0));
    prev_frac = f; prev_rate = rt; prev_err = (r == 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && zero_err_o == 0, "R1 ctrl", busy_o, 0);
    chk(frac_o == 0 && rate_o == 0, "R1 data", frac_o, 0);
    for (int pi = 0; pi < 13; pi++) begin
      for (int r = 0; r < 256; r++) begin
        run((pi == 12) ? 255 : pi * 23, r, (r % 7) == 3);
      end
    end
    @(negedge clk);
    chk(done_o == 0 && int'(frac_o) == prev_frac && int'(rate_o) == prev_rate,
        "R7 final hold", frac_o, prev_frac);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule